// File: doc/BRIEF.md
# Cycle-Stealing Four-Channel DMA Engine

This block moves single words or blocks between memory locations without the processor's involvement. It borrows the processor's memory buses one window at a time. There are four channels. Each channel is steered to one of three buses: the instruction bus, the X bus or the Y bus. A bus with pending work raises its own hold request and waits for the processor to grant the bus. After the grant, one blank cycle passes, then the pending words are moved one per cycle in fixed channel priority. One final blank cycle follows before the hold request is dropped. The X and Y buses run their windows independently, so both can carry a word in the same cycle.

A channel senses its request input in one of two ways. In edge mode, each rising event moves one word. In level mode, words keep moving as long as the request stays high. Addresses are formed from a base and a running offset that wraps after a programmed block length. In the optional double-buffer mode, successive blocks alternate between two halves of a region twice the block length. An edge-mode channel can emit a one-cycle interrupt pulse each time a block boundary is crossed.

Top module: `dma_cs_top`

## Requirements
- R1: After reset, every hold request, bus strobe, write enable and interrupt output is low.
- R2: A bus strobe is issued only in a cycle following one in which that bus's hold acknowledge was high. While acknowledge is withheld, the hold request stays high and no word moves.
- R3: A window that moves n words keeps hold request high for exactly n+2 cycles after the acknowledge is seen: one blank cycle, then n strobe cycles, then one blank release cycle. The strobe is low in the cycle where hold request rises and in the cycle before it falls.
- R4: Channels that are pending on the same bus at the same time are served in one window, lowest channel index first.
- R5: The X bus (select 1) and Y bus (select 2) are served independently, so both can strobe in the same cycle.
- R6: In edge mode (config bit 2 = 0), each rising edge of the request moves exactly one word, however long the request then stays high.
- R7: In level mode (config bit 2 = 1), one word moves per cycle while the request is high. No further word moves in the cycle after it drops.
- R8: Word k of a block is addressed at base + k, for k from 0 to L-1, where L is the block length. After L words the offset returns to 0. Writing the base (field 1) resets the offset. The block length is written to field 2.
- R9: With double buffering (config bit 3 = 1), the first block uses base..base+L-1, the next block uses base+L..base+2L-1, and the blocks then alternate.
- R10: With interrupt enable (config bit 4 = 1) in edge mode, the channel's interrupt output pulses high for one cycle when the last word of each block moves. A level-mode channel never pulses.
- R11: A channel whose bus select (config bits 1:0) is 3 is never served on any bus.
- R12: The bus write enable accompanies a strobe exactly when the served channel has its direction bit (config bit 5) set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_chan | input | 2 | Channel addressed by the write |
| wr_field | input | 2 | 0 config, 1 base, 2 block length |
| wr_data | input | 16 | Write data |
| dreq | input | 4 | Per-channel transfer request |
| hold_ack | input | 3 | Per-bus grant from the processor |
| hold_req | output | 3 | Per-bus hold request |
| bus_strobe | output | 3 | Per-bus word strobe |
| bus_we | output | 3 | Per-bus write enable |
| bus_addr | output | 48 | Per-bus address, 16 bits each, bus 0 lowest |
| bus_chan | output | 6 | Per-bus served channel, 2 bits each |
| dma_irq | output | 4 | Per-channel block interrupt pulse |

## Verification
The checker watches the handshake on every cycle. No strobe may appear without a grant in the previous cycle. The cycle in which the hold request rises carries no strobe, and neither does the cycle before it falls. Each interrupt pulse must last a single cycle. The directed scenarios are needed for behaviour that spans whole windows: the n+2 window length, which channels share a window and in what order, the address sequences with wrap and half-buffer alternation, the difference between edge and level sensing, and the X and Y buses working in parallel.

// File: rtl/dma_cs_pkg.sv
package dma_cs_pkg;
  localparam int BSW = 2;
  localparam int CFG_W = 6;
  localparam logic [1:0] FLD_CFG  = 2'd0;
  localparam logic [1:0] FLD_BASE = 2'd1;
  localparam logic [1:0] FLD_LEN  = 2'd2;

  typedef struct packed {
    logic           wr_dir;
    logic           irq_en;
    logic           dbuf;
    logic           level;
    logic [BSW-1:0] bus;
  } chan_cfg_t;

  typedef enum logic [1:0] {ENG_IDLE, ENG_WAIT, ENG_XFER, ENG_REL} eng_st_t;
endpackage

// File: rtl/dma_cs_chan.sv
module dma_cs_chan
  import dma_cs_pkg::*;
#(
  parameter int AW = 16
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           wr_hit,
  input  logic [1:0]     wr_field,
  input  logic [AW-1:0]  wr_data,
  input  logic           dreq,
  input  logic           serve,
  output logic           elig,
  output logic [BSW-1:0] bus_sel,
  output logic           wr_dir,
  output logic [AW-1:0]  cur_addr,
  output logic           irq
);
  chan_cfg_t     cfg;
  logic [AW-1:0] base, blen, offs;
  logic          half, pend, req_q;
  logic          rise, last;

  assign rise = dreq & ~req_q;
  assign last = ({1'b0, offs} + (AW+1)'(1)) >= {1'b0, blen};

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg   <= '0;
      base  <= '0;
      blen  <= '0;
      offs  <= '0;
      half  <= 1'b0;
      pend  <= 1'b0;
      req_q <= 1'b0;
      irq   <= 1'b0;
    end else begin
      req_q <= dreq;
      irq   <= 1'b0;
      // edge-sensed pending flag: set by a rising event, consumed by a served word
      pend  <= rise | (pend & ~serve);
      if (serve) begin
        offs <= last ? '0 : offs + AW'(1);
        if (last && cfg.dbuf) half <= ~half;
        irq  <= last & ~cfg.level & cfg.irq_en;
      end
      if (wr_hit) begin
        case (wr_field)
          FLD_CFG: begin
            cfg  <= chan_cfg_t'(wr_data[CFG_W-1:0]);
            pend <= 1'b0;
          end
          FLD_BASE: begin
            base <= wr_data;
            offs <= '0;
            half <= 1'b0;
          end
          FLD_LEN: blen <= wr_data;
          default: ;
        endcase
      end
    end
  end

  assign elig     = cfg.level ? dreq : pend;
  assign bus_sel  = cfg.bus;
  assign wr_dir   = cfg.wr_dir;
  assign cur_addr = base + (half ? blen : '0) + offs;
endmodule

// File: rtl/dma_cs_eng.sv
module dma_cs_eng
  import dma_cs_pkg::*;
#(
  parameter int NCH    = 4,
  parameter int AW     = 16,
  parameter int BUS_ID = 0,
  localparam int CW    = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NCH-1:0]     elig,
  input  logic [NCH*BSW-1:0] sel,
  input  logic [NCH*AW-1:0]  addr_in,
  input  logic [NCH-1:0]     dir_in,
  input  logic               hold_ack,
  output logic               hold_req,
  output logic               strobe,
  output logic               we,
  output logic [AW-1:0]      addr,
  output logic [CW-1:0]      chan,
  output logic               fire,
  output logic [CW-1:0]      gidx
);
  eng_st_t        st, nxt;
  logic [NCH-1:0] hit;
  logic           found;

  always_comb begin
    for (int c = 0; c < NCH; c++)
      hit[c] = elig[c] && (sel[c*BSW +: BSW] == BSW'(BUS_ID));
  end

  // fixed priority: lowest index wins
  always_comb begin
    found = 1'b0;
    gidx  = '0;
    for (int c = NCH-1; c >= 0; c--) begin
      if (hit[c]) begin
        found = 1'b1;
        gidx  = CW'(c);
      end
    end
  end

  assign fire = (st == ENG_XFER) && found && hold_ack;

  always_comb begin
    nxt = st;
    case (st)
      ENG_IDLE: if (found) nxt = ENG_WAIT;
      ENG_WAIT: if (hold_ack) nxt = ENG_XFER;
      ENG_XFER: if (!fire) nxt = ENG_REL;
      ENG_REL:  nxt = ENG_IDLE;
      default:  nxt = ENG_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= ENG_IDLE;
      hold_req <= 1'b0;
      strobe   <= 1'b0;
      we       <= 1'b0;
      addr     <= '0;
      chan     <= '0;
    end else begin
      st       <= nxt;
      hold_req <= (nxt != ENG_IDLE);
      strobe   <= fire;
      we       <= fire && dir_in[gidx];
      addr     <= fire ? addr_in[gidx*AW +: AW] : '0;
      chan     <= fire ? gidx : '0;
    end
  end
endmodule

// File: rtl/dma_cs_top.sv
module dma_cs_top
  import dma_cs_pkg::*;
#(
  parameter int NCH = 4,
  parameter int NB  = 3,
  parameter int AW  = 16,
  localparam int CW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [CW-1:0]    wr_chan,
  input  logic [1:0]       wr_field,
  input  logic [AW-1:0]    wr_data,
  input  logic [NCH-1:0]   dreq,
  input  logic [NB-1:0]    hold_ack,
  output logic [NB-1:0]    hold_req,
  output logic [NB-1:0]    bus_strobe,
  output logic [NB-1:0]    bus_we,
  output logic [NB*AW-1:0] bus_addr,
  output logic [NB*CW-1:0] bus_chan,
  output logic [NCH-1:0]   dma_irq
);
  logic [NCH-1:0]     elig, dir, serve;
  logic [NCH*BSW-1:0] sel;
  logic [NCH*AW-1:0]  caddr;
  logic [NB-1:0]      fire;
  logic [NB*CW-1:0]   gidx;

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    dma_cs_chan #(.AW(AW)) u_ch (
      .clk      (clk),
      .rst      (rst),
      .wr_hit   (wr_en && (wr_chan == CW'(c))),
      .wr_field (wr_field),
      .wr_data  (wr_data),
      .dreq     (dreq[c]),
      .serve    (serve[c]),
      .elig     (elig[c]),
      .bus_sel  (sel[c*BSW +: BSW]),
      .wr_dir   (dir[c]),
      .cur_addr (caddr[c*AW +: AW]),
      .irq      (dma_irq[c])
    );
  end

  for (genvar b = 0; b < NB; b++) begin : g_bus
    dma_cs_eng #(.NCH(NCH), .AW(AW), .BUS_ID(b)) u_eng (
      .clk      (clk),
      .rst      (rst),
      .elig     (elig),
      .sel      (sel),
      .addr_in  (caddr),
      .dir_in   (dir),
      .hold_ack (hold_ack[b]),
      .hold_req (hold_req[b]),
      .strobe   (bus_strobe[b]),
      .we       (bus_we[b]),
      .addr     (bus_addr[b*AW +: AW]),
      .chan     (bus_chan[b*CW +: CW]),
      .fire     (fire[b]),
      .gidx     (gidx[b*CW +: CW])
    );
  end

  always_comb begin
    serve = '0;
    for (int b = 0; b < NB; b++)
      if (fire[b]) serve[gidx[b*CW +: CW]] = 1'b1;
  end
endmodule

// File: rtl/dma_cs_chk.sv
module dma_cs_chk #(
  parameter int NCH = 4,
  parameter int NB  = 3
) (
  input logic           clk,
  input logic           rst,
  input logic [NB-1:0]  hold_req,
  input logic [NB-1:0]  hold_ack,
  input logic [NB-1:0]  bus_strobe,
  input logic [NCH-1:0] dma_irq
);
  for (genvar b = 0; b < NB; b++) begin : g_b
    // R2
    strobe_needs_req_chk: assert property (@(posedge clk) disable iff (rst)
      bus_strobe[b] |-> hold_req[b]);
    // R2
    strobe_after_ack_chk: assert property (@(posedge clk) disable iff (rst)
      bus_strobe[b] |-> $past(hold_ack[b]));
    // R3
    blank_first_chk: assert property (@(posedge clk) disable iff (rst)
      $rose(hold_req[b]) |-> !bus_strobe[b]);
    // R3
    blank_release_chk: assert property (@(posedge clk) disable iff (rst)
      $fell(hold_req[b]) |-> !$past(bus_strobe[b]));
  end
  for (genvar c = 0; c < NCH; c++) begin : g_c
    // R10
    irq_pulse_chk: assert property (@(posedge clk) disable iff (rst)
      dma_irq[c] |=> !dma_irq[c]);
  end
endmodule

bind dma_cs_top dma_cs_chk #(.NCH(NCH), .NB(NB)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .hold_req   (hold_req),
  .hold_ack   (hold_ack),
  .bus_strobe (bus_strobe),
  .dma_irq    (dma_irq)
);

// File: tb/tb_dma_cs_top.sv
module tb_dma_cs_top;
  localparam int CLK_PER = 10;
  localparam int NCH = 4, NB = 3, AW = 16, CW = 2;

  logic clk = 0, rst = 1, wr_en = 0;
  logic [CW-1:0] wr_chan = 0;
  logic [1:0] wr_field = 0;
  logic [AW-1:0] wr_data = 0;
  logic [NCH-1:0] dreq = 0;
  logic [NB-1:0] hold_ack = 0, ack_en = '1;
  logic [NB-1:0] hold_req, bus_strobe, bus_we;
  logic [NB*AW-1:0] bus_addr;
  logic [NB*CW-1:0] bus_chan;
  logic [NCH-1:0] dma_irq;

  dma_cs_top #(.NCH(NCH), .NB(NB), .AW(AW)) dut (.*);

  always #(CLK_PER/2) clk = ~clk;

  int n_chk = 0, n_bad = 0;
  bit done = 0;
  int stb_cnt[NB], win_cnt[NB], win_len[NB], cur_len[NB], we_cnt[NB];
  int irq_cnt[NCH];
  int both_xy = 0;
  logic [NB-1:0] prev_req = 0;
  logic [AW-1:0] log_addr[NB][64];
  int log_ch[NB][64];

  // monitor and processor grant model
  always @(negedge clk) begin
    if (!rst) begin
      for (int b = 0; b < NB; b++) begin
        if (hold_req[b] && hold_ack[b]) cur_len[b]++;
        if (!hold_req[b] && prev_req[b]) begin
          win_len[b] = cur_len[b]; cur_len[b] = 0; win_cnt[b]++;
        end
        if (bus_strobe[b]) begin
          log_addr[b][stb_cnt[b] % 64] = bus_addr[b*AW +: AW];
          log_ch[b][stb_cnt[b] % 64] = int'(bus_chan[b*CW +: CW]);
          stb_cnt[b]++;
          if (bus_we[b]) we_cnt[b]++;
        end
        prev_req[b] = hold_req[b];
        hold_ack[b] = hold_req[b] & ack_en[b];
      end
      if (bus_strobe[1] && bus_strobe[2]) both_xy++;
      for (int c = 0; c < NCH; c++) if (dma_irq[c]) irq_cnt[c]++;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic wr(input int ch, input logic [1:0] f, input int d);
    cyc(1);
    wr_en = 1; wr_chan = CW'(ch); wr_field = f; wr_data = AW'(d);
    cyc(1);
    wr_en = 0;
  endtask

  task automatic pulse(input int ch);
    cyc(1); dreq[ch] = 1;
    cyc(2); dreq[ch] = 0;
    cyc(12);
  endtask

  task automatic t_reset();
    chk(hold_req == 0, "R1 hold_req", int'(hold_req), 0);
    chk(bus_strobe == 0 && bus_we == 0, "R1 strobe/we", int'(bus_strobe), 0);
    chk(dma_irq == 0, "R1 irq", int'(dma_irq), 0);
  endtask

  task automatic t_edge_single();
    int s0 = stb_cnt[1], w0 = win_cnt[1], e0 = we_cnt[1];
    wr(0, 2'd0, 'h21); wr(0, 2'd1, 'h100); wr(0, 2'd2, 4);
    cyc(1); dreq[0] = 1;
    cyc(20);
    chk(stb_cnt[1] - s0 == 1, "R6 one word per edge", stb_cnt[1] - s0, 1);
    chk(win_cnt[1] - w0 == 1, "R6 one window", win_cnt[1] - w0, 1);
    chk(win_len[1] == 3, "R3 window n+2", win_len[1], 3);
    chk(log_addr[1][s0 % 64] == 'h100, "R8 first addr", int'(log_addr[1][s0 % 64]), 'h100);
    chk(we_cnt[1] - e0 == 1, "R12 write dir", we_cnt[1] - e0, 1);
    dreq[0] = 0;
    cyc(4);
  endtask

  task automatic t_wrap();
    int s0 = stb_cnt[1];
    int exp[4] = '{'h101, 'h102, 'h103, 'h100};
    for (int i = 0; i < 4; i++) pulse(0);
    for (int i = 0; i < 4; i++)
      chk(log_addr[1][(s0 + i) % 64] == AW'(exp[i]), "R8 address wrap",
          int'(log_addr[1][(s0 + i) % 64]), exp[i]);
    chk(irq_cnt[0] == 0, "R10 irq disabled", irq_cnt[0], 0);
  endtask

  task automatic t_merge();
    int s0 = stb_cnt[1], w0 = win_cnt[1], e0 = we_cnt[1];
    int exp[3] = '{0, 1, 3};
    wr(1, 2'd0, 'h01); wr(1, 2'd1, 'h200); wr(1, 2'd2, 8);
    wr(3, 2'd0, 'h01); wr(3, 2'd1, 'h300); wr(3, 2'd2, 8);
    wr(0, 2'd1, 'h100);
    cyc(1); dreq[3] = 1; dreq[1] = 1; dreq[0] = 1;
    cyc(2); dreq = 0;
    cyc(14);
    chk(win_cnt[1] - w0 == 1, "R4 single window", win_cnt[1] - w0, 1);
    chk(stb_cnt[1] - s0 == 3, "R4 word count", stb_cnt[1] - s0, 3);
    for (int i = 0; i < 3; i++)
      chk(log_ch[1][(s0 + i) % 64] == exp[i], "R4 priority order", log_ch[1][(s0 + i) % 64], exp[i]);
    chk(win_len[1] == 5, "R3 merged window n+2", win_len[1], 5);
    chk(we_cnt[1] - e0 == 1, "R12 only ch0 writes", we_cnt[1] - e0, 1);
  endtask

  task automatic t_concurrent();
    int x0 = both_xy, y0 = stb_cnt[2];
    wr(2, 2'd0, 'h02); wr(2, 2'd1, 'h400); wr(2, 2'd2, 8);
    cyc(1); dreq[0] = 1; dreq[2] = 1;
    cyc(2); dreq = 0;
    cyc(12);
    chk(both_xy - x0 == 1, "R5 X and Y same cycle", both_xy - x0, 1);
    chk(log_addr[2][y0 % 64] == 'h400, "R5 Y addr", int'(log_addr[2][y0 % 64]), 'h400);
  endtask

  task automatic t_level();
    int s0 = stb_cnt[2], w0 = win_cnt[2], i0 = irq_cnt[2], seen = 0;
    wr(2, 2'd0, 'h16); wr(2, 2'd1, 'h500); wr(2, 2'd2, 2);
    cyc(1); dreq[2] = 1;
    for (int k = 0; k < 60 && seen < 5; k++) begin
      @(negedge clk); #1;
      if (bus_strobe[2]) seen++;
    end
    dreq[2] = 0;
    cyc(10);
    chk(stb_cnt[2] - s0 == 5, "R7 level word count", stb_cnt[2] - s0, 5);
    chk(win_cnt[2] - w0 == 1, "R7 one window", win_cnt[2] - w0, 1);
    chk(win_len[2] == 7, "R3 level window n+2", win_len[2], 7);
    chk(irq_cnt[2] - i0 == 0, "R10 no irq in level mode", irq_cnt[2] - i0, 0);
  endtask

  task automatic t_dbuf();
    int s0 = stb_cnt[1], i0 = irq_cnt[1];
    int exp[5] = '{'h40, 'h41, 'h42, 'h43, 'h40};
    wr(1, 2'd0, 'h19); wr(1, 2'd1, 'h40); wr(1, 2'd2, 2);
    for (int i = 0; i < 5; i++) pulse(1);
    for (int i = 0; i < 5; i++)
      chk(log_addr[1][(s0 + i) % 64] == AW'(exp[i]), "R9 half alternation",
          int'(log_addr[1][(s0 + i) % 64]), exp[i]);
    chk(irq_cnt[1] - i0 == 2, "R10 irq per block", irq_cnt[1] - i0, 2);
  endtask

  task automatic t_noack();
    int s0 = stb_cnt[0];
    ack_en[0] = 0;
    wr(3, 2'd0, 'h00); wr(3, 2'd1, 'h600); wr(3, 2'd2, 4);
    pulse(3);
    chk(hold_req[0] == 1, "R2 request held", int'(hold_req[0]), 1);
    chk(stb_cnt[0] - s0 == 0, "R2 no strobe without ack", stb_cnt[0] - s0, 0);
    ack_en[0] = 1;
    cyc(10);
    chk(stb_cnt[0] - s0 == 1, "R2 word after ack", stb_cnt[0] - s0, 1);
    chk(log_addr[0][s0 % 64] == 'h600, "R2 addr", int'(log_addr[0][s0 % 64]), 'h600);
  endtask

  task automatic t_unmapped();
    int tw = win_cnt[0] + win_cnt[1] + win_cnt[2];
    wr(3, 2'd0, 'h03);
    pulse(3);
    chk(hold_req == 0, "R11 no hold", int'(hold_req), 0);
    chk(win_cnt[0] + win_cnt[1] + win_cnt[2] == tw, "R11 never served",
        win_cnt[0] + win_cnt[1] + win_cnt[2] - tw, 0);
  endtask

  initial begin
    cyc(3);
    t_reset();
    rst = 0;
    cyc(2);
    t_edge_single();
    t_wrap();
    t_merge();
    t_concurrent();
    t_level();
    t_dbuf();
    t_noack();
    t_unmapped();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule